// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a synthesizable model of a parallel NOR flash that speaks a command-driven protocol over a simple synchronous bus. Software does not write to the array directly. Each bus write is read as a command, a confirm code, a word count or a data word, and which of these it is depends on the operation already pending. The pending operation also selects what a bus read returns: array contents, the status register, an identifier code or a byte of the query table.

Storage is an internal word array made of whole sectors. Single-word program and buffered multi-word writes update words in one cycle. Sector erase is done by a sequencer that fills one word with all-ones bytes per clock. While it runs the device reports busy and ignores the bus. Bit 7 of the 8-bit status register means "ready". Byte lanes are little-endian: lane 0 holds the byte at the lowest address. The command byte is always `bus_wdata[7:0]`. Array accesses use word address `bus_addr >> log2(PORT_BYTES)`.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset the device is in array-read mode, `bus_rdata` is zero and the status register is 0x00.
- R2: A read with `bus_re` high returns its value on `bus_rdata` one clock later. `bus_rdata` holds its value in any cycle without `bus_re`.
- R3: Writing 0x10 or 0x40 in array mode arms a program. The next write stores its full data word at its address, sets status bit 7 and returns to array-read mode.
- R4: Writing 0x20 and then 0xD0 erases the sector that holds the confirm write's address. The sector base is that address with its low log2(SECTOR_BYTES) bits cleared. Every byte of that sector becomes 0xFF, one word per clock over SECTOR_BYTES/PORT_BYTES clocks, and other sectors keep their contents.
- R5: After 0x20, a second write of 0xFF, or of any value other than 0xD0, returns to array-read mode and erases nothing.
- R6: While the erase runs, status reads show bit 7 as 0 and bus writes have no effect. When the erase ends, the device is in status-read mode with status 0x80.
- R7: Writing 0xE8 sets status bit 7 and starts a buffered write. The next write gives a count N (low 8 data bits), the N+1 writes after it each store their data at their own address, and a final 0xD0 returns to array-read mode.
- R8: Writing 0x50 clears the status register to 0x00 and enters array-read mode. In array-read, status-read or identifier mode, writing 0xFF or 0x00 enters array-read mode.
- R9: After 0x70, and while a program, erase, lock or buffered write is pending, reads return the status register zero-extended to the port width.
- R10: After 0x90, the word index is the low 8 address bits shifted right by log2(PORT_BYTES). Index 0 reads `{ID_B0,ID_B1}`, index 1 reads `{ID_B2,ID_B3}`, and any other index reads zero.
- R11: After 0x98, reads return query table byte [word index]. Bytes 0x10, 0x11 and 0x12 are 0x51, 0x52 and 0x59, and byte 0x27 is log2 of the total byte size. An index of 0x52 or more reads zero. Only 0xFF leaves query mode, and other writes are ignored.
- R12: Writing 0x60 arms lock/unlock. A following 0xD0 or 0x01 sets status bit 7 and enters status-read mode. Any other value returns to array-read mode.
- R13: Any unlisted command byte written in array-read mode leaves the device in array-read mode with nothing pending.
- R14: When a read and a write fall in the same cycle, the read returns what the device showed before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DW | Write data; the command byte is bits 7:0 |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DW | Registered read data |

## Verification
Two things can share a cycle: the erase sequencer writing a word of the array, and a bus write that would otherwise program a word. The bench issues a program command and its data while the erase is still running, aimed at a word in another sector. Afterwards it checks that the erased sector is all ones and that the targeted word still holds its old value. The other pairing is a read and a command write in the same cycle. Here the bench expects the returned word to come from the mode in force before the write, and expects the next read to come from the new mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] OP_NULL       = 8'h00;
    localparam logic [7:0] OP_PROG_A     = 8'h10;
    localparam logic [7:0] OP_ERASE      = 8'h20;
    localparam logic [7:0] OP_PROG_B     = 8'h40;
    localparam logic [7:0] OP_CLR_STAT   = 8'h50;
    localparam logic [7:0] OP_LOCK       = 8'h60;
    localparam logic [7:0] OP_RD_STAT    = 8'h70;
    localparam logic [7:0] OP_RD_ID      = 8'h90;
    localparam logic [7:0] OP_QUERY      = 8'h98;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_BUF_WR     = 8'hE8;
    localparam logic [7:0] OP_ARRAY      = 8'hFF;
    localparam logic [7:0] OP_LOCK_ALT   = 8'h01;
    localparam int unsigned QUERY_LEN    = 8'h52;
    localparam logic [7:0] READY_BIT     = 8'h80;

    typedef enum logic [3:0] {
        FS_ARRAY, FS_STATUS, FS_IDENT, FS_QUERY, FS_PROG,
        FS_ERASE_CFM, FS_ERASING, FS_LOCK,
        FS_BUF_COUNT, FS_BUF_DATA, FS_BUF_CFM
    } fsm_state_e;

    typedef enum logic [1:0] {
        RS_ARRAY, RS_STATUS, RS_IDENT, RS_QUERY
    } rd_src_e;

    typedef struct packed {
        logic store_we;
        logic erase_go;
        logic status_set;
        logic status_clr;
    } cmd_ctl_t;

    function automatic rd_src_e rd_source(input fsm_state_e s);
        case (s)
            FS_ARRAY: return RS_ARRAY;
            FS_IDENT: return RS_IDENT;
            FS_QUERY: return RS_QUERY;
            default:  return RS_STATUS;
        endcase
    endfunction

    function automatic logic accepts_cmd(input fsm_state_e s);
        return (s == FS_ARRAY) || (s == FS_STATUS) || (s == FS_IDENT);
    endfunction

    function automatic logic [7:0] query_byte(
        input logic [7:0] idx,
        input int unsigned total_log2,
        input int unsigned buf_log2,
        input int unsigned sectors,
        input int unsigned sector_bytes
    );
        logic [7:0] v;
        if (32'(idx) >= QUERY_LEN) return 8'h00;
        case (idx)
            8'h10: v = 8'h51;
            8'h11: v = 8'h52;
            8'h12: v = 8'h59;
            8'h13: v = 8'h01;
            8'h15: v = 8'h31;
            8'h1B: v = 8'h45;
            8'h1C: v = 8'h55;
            8'h1F: v = 8'h07;
            8'h20: v = 8'h07;
            8'h21: v = 8'h0A;
            8'h23: v = 8'h04;
            8'h24: v = 8'h04;
            8'h25: v = 8'h04;
            8'h27: v = 8'(total_log2);
            8'h28: v = 8'h02;
            8'h2A: v = 8'(buf_log2);
            8'h2C: v = 8'h01;
            8'h2D: v = 8'(sectors - 1);
            8'h2E: v = 8'((sectors - 1) >> 8);
            8'h2F: v = 8'(sector_bytes >> 8);
            8'h30: v = 8'(sector_bytes >> 16);
            8'h31: v = 8'h50;
            8'h32: v = 8'h52;
            8'h33: v = 8'h49;
            8'h34: v = 8'h31;
            8'h35: v = 8'h31;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fcmd_fsm.sv
module fcmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [7:0]       cmd,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             erase_done,
    output fsm_state_e       state,
    output cmd_ctl_t         ctl,
    output logic [7:0]       status
);

    fsm_state_e       nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    always_comb begin
        nxt     = state;
        ctl     = '0;
        cnt_nxt = cnt_q;
        if (state == FS_ERASING) begin
            if (erase_done) begin
                nxt            = FS_STATUS;
                ctl.status_set = 1'b1;
            end
        end else if (we) begin
            case (state)
                FS_ARRAY, FS_STATUS, FS_IDENT: begin
                    case (cmd)
                        OP_PROG_A, OP_PROG_B: nxt = FS_PROG;
                        OP_ERASE:    nxt = FS_ERASE_CFM;
                        OP_CLR_STAT: begin
                            ctl.status_clr = 1'b1;
                            nxt            = FS_ARRAY;
                        end
                        OP_LOCK:     nxt = FS_LOCK;
                        OP_RD_STAT:  nxt = FS_STATUS;
                        OP_RD_ID:    nxt = FS_IDENT;
                        OP_QUERY:    nxt = FS_QUERY;
                        OP_BUF_WR: begin
                            ctl.status_set = 1'b1;
                            nxt            = FS_BUF_COUNT;
                        end
                        default:     nxt = FS_ARRAY;
                    endcase
                end
                FS_QUERY: begin
                    if (cmd == OP_ARRAY) nxt = FS_ARRAY;
                end
                FS_PROG: begin
                    ctl.store_we   = 1'b1;
                    ctl.status_set = 1'b1;
                    nxt            = FS_ARRAY;
                end
                FS_ERASE_CFM: begin
                    if (cmd == OP_CONFIRM) begin
                        ctl.erase_go = 1'b1;
                        nxt          = FS_ERASING;
                    end else begin
                        nxt = FS_ARRAY;
                    end
                end
                FS_LOCK: begin
                    if (cmd == OP_CONFIRM || cmd == OP_LOCK_ALT) begin
                        ctl.status_set = 1'b1;
                        nxt            = FS_STATUS;
                    end else begin
                        nxt = FS_ARRAY;
                    end
                end
                FS_BUF_COUNT: begin
                    cnt_nxt = cnt_in;
                    nxt     = FS_BUF_DATA;
                end
                FS_BUF_DATA: begin
                    ctl.store_we   = 1'b1;
                    ctl.status_set = 1'b1;
                    if (cnt_q == '0) nxt = FS_BUF_CFM;
                    else             cnt_nxt = cnt_q - 1'b1;
                end
                FS_BUF_CFM: begin
                    if (cmd == OP_CONFIRM) ctl.status_set = 1'b1;
                    nxt = FS_ARRAY;
                end
                default: nxt = FS_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FS_ARRAY;
            status <= 8'h00;
            cnt_q  <= '0;
        end else begin
            state <= nxt;
            cnt_q <= cnt_nxt;
            if (ctl.status_clr)      status <= 8'h00;
            else if (ctl.erase_go)   status <= status & ~READY_BIT;
            else if (ctl.status_set) status <= status | READY_BIT;
        end
    end

endmodule

// File: rtl/fcmd_erase_seq.sv
module fcmd_erase_seq #(
    parameter int WORD_AW    = 7,
    parameter int SECT_WORDS = 32,
    localparam int PTR_W     = $clog2(SECT_WORDS),
    localparam int SECT_W    = WORD_AW - PTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [SECT_W-1:0]  sector,
    output logic               busy,
    output logic               done,
    output logic               we,
    output logic [WORD_AW-1:0] waddr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(SECT_WORDS - 1);

    logic [PTR_W-1:0]  ptr;
    logic [SECT_W-1:0] sect_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            ptr    <= '0;
            sect_q <= '0;
        end else if (go) begin
            busy   <= 1'b1;
            ptr    <= '0;
            sect_q <= sector;
        end else if (busy) begin
            if (ptr == LAST) busy <= 1'b0;
            ptr <= ptr + 1'b1;
        end
    end

    assign done  = busy && (ptr == LAST);
    assign we    = busy;
    assign waddr = {sect_q, ptr};

endmodule

// File: rtl/fcmd_store.sv
module fcmd_store #(
    parameter int DW      = 16,
    parameter int WORD_AW = 7,
    localparam int WORDS  = 1 << WORD_AW
) (
    input  logic               clk,
    input  logic               we,
    input  logic [WORD_AW-1:0] waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [WORD_AW-1:0] raddr,
    output logic [DW-1:0]      rdata
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int         PORT_BYTES   = 2,
    parameter int         SECTOR_BYTES = 64,
    parameter int         NUM_SECTORS  = 4,
    parameter int         CNT_W        = 8,
    parameter logic [7:0] ID_B0        = 8'h00,
    parameter logic [7:0] ID_B1        = 8'h89,
    parameter logic [7:0] ID_B2        = 8'h00,
    parameter logic [7:0] ID_B3        = 8'h18,
    localparam int DW          = 8 * PORT_BYTES,
    localparam int TOTAL_BYTES = SECTOR_BYTES * NUM_SECTORS,
    localparam int ADDR_W      = $clog2(TOTAL_BYTES),
    localparam int BYTE_SH     = $clog2(PORT_BYTES),
    localparam int WORD_AW     = ADDR_W - BYTE_SH,
    localparam int SECT_WORDS  = SECTOR_BYTES / PORT_BYTES,
    localparam int PTR_W       = $clog2(SECT_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DW-1:0]     bus_rdata
);

    localparam int unsigned BUF_LOG2 = BYTE_SH + CNT_W;

    fsm_state_e         state;
    cmd_ctl_t           ctl;
    logic [7:0]         status;
    logic               erase_busy, erase_done, erase_we;
    logic [WORD_AW-1:0] erase_waddr;
    logic [WORD_AW-1:0] word_idx;
    logic [WORD_AW-1:0] st_waddr;
    logic [DW-1:0]      st_wdata, array_word;
    logic               st_we;
    logic [ADDR_W+7:0]  addr_ext;
    logic [7:0]         widx;
    logic [DW-1:0]      rd_mux;

    assign word_idx = bus_addr[ADDR_W-1:BYTE_SH];
    assign addr_ext = {8'h00, bus_addr};
    assign widx     = addr_ext[7:0] >> BYTE_SH;

    fcmd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .we         (bus_we),
        .cmd        (bus_wdata[7:0]),
        .cnt_in     (bus_wdata[CNT_W-1:0]),
        .erase_done (erase_done),
        .state      (state),
        .ctl        (ctl),
        .status     (status)
    );

    fcmd_erase_seq #(.WORD_AW(WORD_AW), .SECT_WORDS(SECT_WORDS)) u_erase (
        .clk    (clk),
        .rst    (rst),
        .go     (ctl.erase_go),
        .sector (word_idx[WORD_AW-1:PTR_W]),
        .busy   (erase_busy),
        .done   (erase_done),
        .we     (erase_we),
        .waddr  (erase_waddr)
    );

    assign st_we    = erase_we | ctl.store_we;
    assign st_waddr = erase_we ? erase_waddr : word_idx;
    assign st_wdata = erase_we ? {DW{1'b1}} : bus_wdata;

    fcmd_store #(.DW(DW), .WORD_AW(WORD_AW)) u_store (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (word_idx),
        .rdata (array_word)
    );

    always_comb begin
        case (rd_source(state))
            RS_ARRAY:  rd_mux = array_word;
            RS_IDENT: begin
                if (widx == 8'd0)      rd_mux = DW'({ID_B0, ID_B1});
                else if (widx == 8'd1) rd_mux = DW'({ID_B2, ID_B3});
                else                   rd_mux = '0;
            end
            RS_QUERY:  rd_mux = DW'(query_byte(widx, ADDR_W, BUF_LOG2,
                                               NUM_SECTORS, SECTOR_BYTES));
            default:   rd_mux = DW'(status);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/fcmd_checker.sv
module fcmd_checker
    import flash_cmd_pkg::*;
#(
    parameter int DW      = 16,
    parameter int WORD_AW = 7
) (
    input logic               clk,
    input logic               rst,
    input fsm_state_e         state,
    input logic [7:0]         status,
    input logic               erase_busy,
    input logic               erase_we,
    input logic               store_we,
    input logic [WORD_AW-1:0] erase_waddr,
    input logic               bus_we,
    input logic               bus_re,
    input logic [7:0]         cmd,
    input logic [DW-1:0]      bus_rdata
);

    AST_ERASE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        erase_busy |-> !status[7]);                                            // R6

    AST_ERASE_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        $fell(erase_busy) |-> (status[7] && state == FS_STATUS));              // R6

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(erase_we && store_we));                                              // R6

    AST_ERASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (erase_we && $past(erase_we)) |-> erase_waddr == WORD_AW'($past(erase_waddr) + 1'b1)); // R4

    AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && cmd == OP_CLR_STAT && accepts_cmd(state)) |=> (status == 8'h00 && state == FS_ARRAY)); // R8

    AST_PROG_READY: assert property (@(posedge clk) disable iff (rst)
        (bus_we && state == FS_PROG) |=> (status[7] && state == FS_ARRAY));    // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));                                       // R2

endmodule

bind flash_cmd_engine fcmd_checker #(.DW(DW), .WORD_AW(WORD_AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .status      (status),
    .erase_busy  (erase_busy),
    .erase_we    (erase_we),
    .store_we    (ctl.store_we),
    .erase_waddr (erase_waddr),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .cmd         (bus_wdata[7:0]),
    .bus_rdata   (bus_rdata)
);

// File: tb/test_flash_cmd_engine.sv
`timescale 1ns/1ps
module test_flash_cmd_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_engine i_flash_cmd_engine (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 rdata after reset", bus_rdata, 16'h0000);
        @(negedge clk);
        check("R2 rdata holds without read", bus_rdata, 16'h0000);
        wr(8'h00, 16'h0070);
        rd(8'h00, v);
        check("R1 status after reset", v, 16'h0000);
        wr(8'h00, 16'h00FF);
    endtask

    task automatic t_program();
        logic [15:0] v;
        wr(8'h10, 16'h0040);
        wr(8'h10, 16'hBEEF);
        rd(8'h10, v);
        check("R3 program via 0x40", v, 16'hBEEF);
        wr(8'h42, 16'h0010);
        wr(8'h42, 16'h1234);
        rd(8'h42, v);
        check("R3 program via 0x10", v, 16'h1234);
        wr(8'h00, 16'h0070);
        rd(8'h00, v);
        check("R3 R9 status ready after program", v, 16'h0080);
        wr(8'h00, 16'h00FF);
    endtask

    task automatic t_erase();
        logic [15:0] v;
        int polls;
        wr(8'h3E, 16'h0040); wr(8'h3E, 16'h1111);
        wr(8'h44, 16'h0040); wr(8'h44, 16'h5555);
        wr(8'h80, 16'h0040); wr(8'h80, 16'hA5A5);
        wr(8'h00, 16'h0050);
        wr(8'h40, 16'h0020);
        rd(8'h40, v);
        check("R9 status while erase pending", v, 16'h0000);
        wr(8'h46, 16'h00D0);
        rd(8'h46, v);
        check("R6 busy status bit7 low", v & 16'h0080, 16'h0000);
        wr(8'h80, 16'h0040);
        wr(8'h80, 16'h0000);
        polls = 0;
        for (int i = 0; i < 100; i++) begin
            rd(8'h00, v);
            polls++;
            if (v[7]) break;
        end
        check("R6 status after erase", v, 16'h0080);
        check("R4 erase lasts about one clock per word", 16'(polls > 20 && polls < 40), 16'h0001);
        wr(8'h00, 16'h00FF);
        rd(8'h44, v); check("R4 erased word", v, 16'hFFFF);
        rd(8'h40, v); check("R4 sector first word", v, 16'hFFFF);
        rd(8'h7E, v); check("R4 sector last word", v, 16'hFFFF);
        rd(8'h3E, v); check("R4 previous sector kept", v, 16'h1111);
        rd(8'h80, v); check("R6 write during erase ignored", v, 16'hA5A5);
    endtask

    task automatic t_erase_abort();
        logic [15:0] v;
        wr(8'hC0, 16'h0040); wr(8'hC0, 16'h7777);
        wr(8'hC0, 16'h0020); wr(8'hC0, 16'h00FF);
        rd(8'hC0, v); check("R5 abort with 0xFF", v, 16'h7777);
        wr(8'hC0, 16'h0020); wr(8'hC0, 16'h0033);
        rd(8'hC0, v); check("R5 abort with bad confirm", v, 16'h7777);
    endtask

    task automatic t_buffered();
        logic [15:0] v;
        wr(8'h00, 16'h0050);
        wr(8'hA0, 16'h00E8);
        wr(8'hA0, 16'h0002);
        rd(8'hA0, v); check("R7 R9 status during buffered write", v, 16'h0080);
        wr(8'hA0, 16'h0101);
        wr(8'hA2, 16'h0202);
        wr(8'hA4, 16'h0303);
        wr(8'hA0, 16'h00D0);
        rd(8'hA0, v); check("R7 buffered word 0", v, 16'h0101);
        rd(8'hA2, v); check("R7 buffered word 1", v, 16'h0202);
        rd(8'hA4, v); check("R7 buffered word 2", v, 16'h0303);
        wr(8'hB0, 16'h00E8);
        wr(8'hB0, 16'h0000);
        wr(8'hB0, 16'hCAFE);
        wr(8'hB0, 16'h00D0);
        rd(8'hB0, v); check("R7 count zero single word", v, 16'hCAFE);
    endtask

    task automatic t_status_clear();
        logic [15:0] v;
        wr(8'h00, 16'h0070);
        rd(8'h00, v); check("R9 status mode", v, 16'h0080);
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0070);
        rd(8'h00, v); check("R8 status cleared", v, 16'h0000);
        wr(8'h00, 16'h0000);
        rd(8'hB0, v); check("R8 0x00 returns to array", v, 16'hCAFE);
    endtask

    task automatic t_ident();
        logic [15:0] v;
        wr(8'h00, 16'h0090);
        rd(8'h00, v); check("R10 manufacturer code", v, 16'h0089);
        rd(8'h02, v); check("R10 device code", v, 16'h0018);
        rd(8'h03, v); check("R10 unaligned index 1", v, 16'h0018);
        rd(8'h04, v); check("R10 other index zero", v, 16'h0000);
        wr(8'h00, 16'h00FF);
        rd(8'hB0, v); check("R8 0xFF leaves ident", v, 16'hCAFE);
    endtask

    task automatic t_query();
        logic [15:0] v;
        wr(8'h00, 16'h0098);
        rd(8'h20, v); check("R11 query 0x10", v, 16'h0051);
        rd(8'h22, v); check("R11 query 0x11", v, 16'h0052);
        rd(8'h24, v); check("R11 query 0x12", v, 16'h0059);
        rd(8'h4E, v); check("R11 size log2", v, 16'h0008);
        rd(8'hA4, v); check("R11 beyond table", v, 16'h0000);
        wr(8'h00, 16'h0012);
        rd(8'h20, v); check("R11 other write stays in query", v, 16'h0051);
        wr(8'h00, 16'h00FF);
        rd(8'hB0, v); check("R11 0xFF leaves query", v, 16'hCAFE);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0060);
        wr(8'h00, 16'h00D0);
        rd(8'h00, v); check("R12 lock with 0xD0", v, 16'h0080);
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0060);
        wr(8'h00, 16'h0001);
        rd(8'h00, v); check("R12 lock with 0x01", v, 16'h0080);
        wr(8'h00, 16'h0060);
        wr(8'h00, 16'h0055);
        rd(8'hB0, v); check("R12 bad lock value to array", v, 16'hCAFE);
    endtask

    task automatic t_unknown();
        logic [15:0] v;
        wr(8'h00, 16'h0033);
        rd(8'hB0, v); check("R13 unknown command stays array", v, 16'hCAFE);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        bus_addr  = 8'h10;
        bus_wdata = 16'h0070;
        bus_we    = 1'b1;
        bus_re    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
        check("R14 read sees pre-write mode", bus_rdata, 16'hBEEF);
        rd(8'h10, v);
        check("R14 next read sees status", v, 16'h0080);
        wr(8'h00, 16'h00FF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_erase_abort();
        t_buffered();
        t_status_clear();
        t_ident();
        t_query();
        t_lock();
        t_unknown();
        t_same_cycle();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule